// File: doc/BRIEF.md
# Hall-Synchronised Sine Modulation Sequencer

This block sits between the Hall position inputs of a three-phase brushless motor drive and its waveform generator. It counts reference clocks between consecutive Hall transitions, which gives the length of one 60-degree electrical sector. Over the following sector it advances a 5-bit modulation sample index. Each step of the index lasts one thirty-second of the sector length just measured. The index is forced back to zero on every Hall transition, so the modulation stays locked to the rotor even when the rotor speeds up or slows down.

The block also decides how the drive commutates. After reset it uses 120-degree rectangular commutation. It moves to 180-degree sinusoidal drive only when the rotor has run steadily inside a speed window for a number of transitions, and the switch takes effect on a falling edge of phase U. The block reports the current electrical sector for the commanded direction. It flags Hall patterns that cannot occur on a healthy motor, and it removes the drive enable while such a pattern is present.

Top module: `hall_sine_sequencer`

## Requirements
- R1: On a clock with no Hall transition, the sample index advances by one each time STEP clocks have passed since the last advance or the last transition. STEP is the last stored interval shifted right by 5 bits, with a minimum of 1. Just after reset the stored interval is the all-ones value of the counter.
- R2: When the index reaches 31 and no Hall transition has arrived, it wraps to 0 and keeps stepping with the same STEP.
- R3: A Hall transition is a change of the pattern {hall_w,hall_v,hall_u} from the previous clock. In the clock after a transition, the index is 0 and the step timer restarts, whatever the index was before.
- R4: The interval counter holds at its all-ones value instead of wrapping. A transition seen while the counter is held keeps the previously stored interval. A held counter, whether or not a transition comes with it, returns the block to rectangular mode (sine_mode=0).
- R5: After reset sine_mode is 0. Call a transition qualified when its measured interval is neither held nor below FAST_IVL. sine_mode rises on a transition where U falls (hall_u goes from 1 to 0), provided at least EDGES_TO_SINE qualified transitions came before it with no unqualified transition between them.
- R6: In sinusoidal mode, a transition whose measured interval is shorter than FAST_IVL clocks returns the block to rectangular mode and clears the count of qualified transitions.
- R7: The patterns 000 and 111 are invalid. While the registered pattern is invalid, hall_fault=1, drive_en=0, sector=7 and sine_mode=0, and the count of qualified transitions is cleared.
- R8: With dir_ccw=0, the sector is 0 to 5 for the patterns 001, 011, 010, 110, 100, 101 (bits w,v,u); with dir_ccw=1 the sector is (6-s) mod 6 of that value.
- R9: During reset the index is 0, sine_mode is 0, drive_en is 0 and sector is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_u | input | 1 | Debounced Hall level, phase U |
| hall_v | input | 1 | Debounced Hall level, phase V |
| hall_w | input | 1 | Debounced Hall level, phase W |
| dir_ccw | input | 1 | Direction: 0 = U,V,W order, 1 = reverse |
| sample_idx | output | 5 | Modulation sample index within the sector |
| sine_mode | output | 1 | 1 = sinusoidal drive, 0 = rectangular |
| drive_en | output | 1 | 0 while the Hall pattern is invalid |
| hall_fault | output | 1 | Registered Hall pattern is 000 or 111 |
| sector | output | 3 | Electrical sector 0..5, 7 when invalid |

## Verification
The assertions assume that the Hall inputs are already synchronous to clk and debounced, so each change is a single clean transition sampled on one edge. The stimulus changes the Hall levels only on the falling clock edge and holds each pattern for a whole number of cycles. It walks the valid six-step sequences in both directions at steady, fast and stalled speeds, and it injects both invalid patterns. The counter width and speed limit are reduced in the bench, so that saturation and the fast limit are reached in a few thousand cycles.

// File: rtl/hall_sine_sequencer.sv
module hall_sine_sequencer #(
  parameter int CNT_W         = 16,
  parameter int IDX_W         = 5,
  parameter int EDGES_TO_SINE = 6,
  parameter int FAST_IVL      = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hall_u,
  input  logic             hall_v,
  input  logic             hall_w,
  input  logic             dir_ccw,
  output logic [IDX_W-1:0] sample_idx,
  output logic             sine_mode,
  output logic             drive_en,
  output logic             hall_fault,
  output logic [2:0]       sector
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int EN_W = $clog2(EDGES_TO_SINE + 1);
  localparam logic [EN_W-1:0] EDGE_GOAL = EN_W'(EDGES_TO_SINE);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_IVL);

  typedef enum logic {M_RECT, M_SINE} mode_t;

  logic [2:0]       pat, h_q;
  logic             trans, pat_bad, ivl_sat, ivl_ok, u_fall;
  logic [CNT_W-1:0] ivl_cnt, last_ivl, step_per, step_cnt, shifted;
  logic [EN_W-1:0]  edge_n;
  mode_t            mode;
  logic [2:0]       cw_sec;

  assign pat     = {hall_w, hall_v, hall_u};
  assign trans   = pat != h_q;
  assign pat_bad = (pat == 3'b000) || (pat == 3'b111);
  assign ivl_sat = ivl_cnt == CNT_MAX;
  assign ivl_ok  = !ivl_sat && (ivl_cnt >= FAST_LIM);
  assign u_fall  = h_q[0] && !pat[0];
  assign shifted = last_ivl >> IDX_W;
  assign step_per = (shifted == '0) ? CNT_W'(1) : shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q      <= 3'b000;
      ivl_cnt  <= CNT_MAX;
      last_ivl <= CNT_MAX;
    end else begin
      h_q <= pat;
      if (trans) begin
        if (!ivl_sat) last_ivl <= ivl_cnt;
        ivl_cnt <= CNT_W'(1);
      end else if (!ivl_sat) begin
        ivl_cnt <= ivl_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_idx <= '0;
      step_cnt   <= '0;
    end else if (trans) begin
      sample_idx <= '0;
      step_cnt   <= '0;
    end else if ({1'b0, step_cnt} + 1'b1 >= {1'b0, step_per}) begin
      sample_idx <= sample_idx + 1'b1;
      step_cnt   <= '0;
    end else begin
      step_cnt   <= step_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= M_RECT;
      edge_n <= '0;
    end else if (trans && pat_bad) begin
      mode   <= M_RECT;
      edge_n <= '0;
    end else if (trans) begin
      if (!ivl_ok) begin
        mode   <= M_RECT;
        edge_n <= '0;
      end else if (mode == M_RECT) begin
        if (edge_n == EDGE_GOAL && u_fall) mode <= M_SINE;
        else if (edge_n != EDGE_GOAL)      edge_n <= edge_n + 1'b1;
      end
    end else if (ivl_sat) begin
      mode   <= M_RECT;
      edge_n <= '0;
    end
  end

  always_comb begin
    case (h_q)
      3'b001:  cw_sec = 3'd0;
      3'b011:  cw_sec = 3'd1;
      3'b010:  cw_sec = 3'd2;
      3'b110:  cw_sec = 3'd3;
      3'b100:  cw_sec = 3'd4;
      3'b101:  cw_sec = 3'd5;
      default: cw_sec = 3'd7;
    endcase
  end

  assign hall_fault = (h_q == 3'b000) || (h_q == 3'b111);
  assign drive_en   = !hall_fault;
  assign sine_mode  = (mode == M_SINE);
  assign sector     = hall_fault ? 3'd7 :
                      (!dir_ccw || cw_sec == 3'd0) ? cw_sec : 3'd6 - cw_sec;

  p_idx_zero_after_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trans |=> sample_idx == '0);

  p_idx_steps_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_idx) |-> (sample_idx == '0) || (sample_idx == $past(sample_idx) + 1'b1));

  p_sine_on_u_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sine_mode) |-> (h_q[0] == 1'b0) && $past(hall_u) == 1'b0 && $past(h_q[0]) == 1'b1);

  p_fault_blocks_sine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hall_fault |-> !sine_mode && !drive_en && sector == 3'd7);

  p_counter_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ivl_cnt) == CNT_MAX && !$past(trans)) |-> ivl_cnt == CNT_MAX);

  p_sat_leaves_sine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_sat |=> !sine_mode);
endmodule

// File: tb/test_hall_sine_sequencer.sv
module test_hall_sine_sequencer;
  localparam int CW = 10;
  localparam int FAST = 40;
  localparam int GOAL = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hu = 1'b0, hv = 1'b0, hw = 1'b0, ccw = 1'b0;
  logic [4:0] idx;
  logic sine, en, fault;
  logic [2:0] sec;

  always #2 clk = ~clk;

  hall_sine_sequencer #(.CNT_W(CW), .IDX_W(5), .EDGES_TO_SINE(GOAL), .FAST_IVL(FAST)) i_hall_sine_sequencer (
    .clk(clk), .rst_n(rst_n), .hall_u(hu), .hall_v(hv), .hall_w(hw), .dir_ccw(ccw),
    .sample_idx(idx), .sine_mode(sine), .drive_en(en), .hall_fault(fault), .sector(sec));

  int total = 0, bad = 0, cycles = 0;
  int m_hq, m_ivl, m_last, m_idx, m_sc, m_n;
  bit m_sine, m_edge, m_wrap;
  int seq_cw[6] = '{1, 3, 2, 6, 4, 5};

  function automatic int sec_of(int p, bit d);
    for (int k = 0; k < 6; k++)
      if (seq_cw[k] == p) return (d && k != 0) ? 6 - k : k;
    return 7;
  endfunction

  function automatic bit invalid(int p);
    return p == 0 || p == 7;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int pat, per;
    bit sat, good;
    cycles++;
    pat = {hw, hv, hu};
    m_edge = 0; m_wrap = 0;
    if (!rst_n) begin
      m_hq = 0; m_ivl = MAXV; m_last = MAXV; m_idx = 0; m_sc = 0; m_n = 0; m_sine = 0;
    end else begin
      sat  = (m_ivl == MAXV);
      good = !sat && m_ivl >= FAST;
      per  = m_last / 32; if (per < 1) per = 1;
      if (pat != m_hq) begin
        m_edge = 1;
        if (invalid(pat)) begin m_sine = 0; m_n = 0; end
        else if (!good) begin m_sine = 0; m_n = 0; end
        else if (!m_sine) begin
          if (m_n == GOAL && (m_hq & 1) && !(pat & 1)) m_sine = 1;
          else if (m_n < GOAL) m_n++;
        end
        if (!sat) m_last = m_ivl;
        m_ivl = 1; m_idx = 0; m_sc = 0;
      end else begin
        if (sat) begin m_sine = 0; m_n = 0; end
        else m_ivl++;
        if (m_sc + 1 >= per) begin
          m_sc = 0;
          if (m_idx == 31) m_wrap = 1;
          m_idx = (m_idx + 1) % 32;
        end else m_sc++;
      end
      m_hq = pat;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cycles > 0) begin
      if (m_edge) chk("R3 index after transition", idx, 0);
      else if (m_wrap) chk("R2 index wrap", idx, 0);
      else chk("R1 sample index", idx, m_idx);
      chk("R5 sine_mode", sine, m_sine);
      chk("R7 hall_fault", fault, invalid(m_hq));
      chk("R7 drive_en", en, !invalid(m_hq));
      chk("R8 sector", sec, sec_of(m_hq, ccw));
    end
  end

  task automatic put(int p, int gap);
    @(negedge clk);
    {hw, hv, hu} = p[2:0];
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic spin(bit dir, int n, int gap);
    for (int k = 0; k < n; k++) put(seq_cw[dir ? 5 - (k % 6) : (k % 6)], gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset index", idx, 0);
    chk("R9 reset sine_mode", sine, 0);
    chk("R9 reset drive_en", en, 0);
    chk("R9 reset sector", sec, 7);
    rst_n = 1'b1;
    spin(0, 14, 320);
    chk("R5 sinusoidal after steady run", sine, 1);
    put(seq_cw[2], 100);
    put(seq_cw[3], 400);
    put(seq_cw[4], 1200);
    chk("R4 stall returns to rectangular", sine, 0);
    spin(0, 14, 20);
    chk("R6 fast run stays rectangular", sine, 0);
    spin(0, 14, 200);
    chk("R5 second steady run", sine, 1);
    spin(0, 3, 25);
    chk("R6 fast transition leaves sinusoidal", sine, 0);
    put(0, 30);
    chk("R7 all-low flagged", fault, 1);
    put(7, 30);
    chk("R7 all-high flagged", fault, 1);
    chk("R7 all-high no sine", sine, 0);
    ccw = 1'b1;
    spin(1, 14, 150);
    @(negedge clk);
    chk("R8 ccw sector range", (sec < 6), 1);
    ccw = 1'b0;
    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule